// File: doc/BRIEF.md
# Broadcast and Multicast Packet Rate Limiter

This block caps how many broadcast and how many multicast packets each port of a three-port switch may pass in a fixed time window. Upstream classification logic raises one strobe per packet. The strobe carries the port number, the direction as seen by that port, and flags that mark broadcast and multicast. One cycle later the block returns a forward or drop decision.

A free-running prescaler marks the window boundaries. Its default length is 100 ms at a 125 MHz clock. Each port has two counters, one for broadcast and one for multicast, and each counter is compared with its own programmed limit in the range 0 to 255. A single global bit chooses whether limiting acts on transmit traffic or on receive traffic. Port 0 is the host port, so transmit and receive are swapped for it. Each port also has its own enable.

Top module: `bmc_rate_limiter`

## Requirements
- R1: While reset is held and after it is released, `decValid` and `decDrop` are low, every counter is empty, and the window prescaler starts from zero.
- R2: Each cycle in which `pktValid` is high produces exactly one decision on `decValid`/`decDrop` in the next cycle. `decDrop` is low whenever `decValid` is low.
- R3: For a limited port and type with limit L, the first L packets of that type in a window are forwarded. Every later packet of that type in the same window is dropped.
- R4: Each port has its own broadcast count and its own multicast count, and none of these counts affects another.
- R5: A limit of 0 drops every limited packet of that type. A limit of 255 forwards exactly 255 packets per window.
- R6: A window boundary occurs in the cycle whose prescaler value is WINDOW_CYCLES-1, counting from 0 after reset. In that cycle all counters clear together, and a packet arriving in that same cycle is counted against the new window.
- R7: `limitRx` = 0 limits transmit traffic and `limitRx` = 1 limits receive traffic. Packets in the other direction are always forwarded and leave the counters unchanged.
- R8: `pktRx` is 1 for receive and 0 for transmit as seen by the port. On port 0 its meaning is inverted before it is compared with `limitRx`.
- R9: A packet on a port whose `portEnable` bit is 0 is forwarded and is not counted, whatever limit is programmed.
- R10: A packet with neither `pktBcast` nor `pktMcast` set is forwarded and leaves every counter unchanged.
- R11: A packet with both `pktBcast` and `pktMcast` set is treated as broadcast.
- R12: A packet with port number 3 (outside 0..2) is forwarded and is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| limitRx | input | 1 | 0: limit transmit traffic, 1: limit receive traffic |
| portEnable | input | 3 | Per-port limiting enable, bit n for port n |
| bcastLimit | input | 24 | Broadcast limits, bits [8n+7:8n] for port n |
| mcastLimit | input | 24 | Multicast limits, bits [8n+7:8n] for port n |
| pktValid | input | 1 | Packet classification strobe |
| pktPort | input | 2 | Port number of the packet |
| pktRx | input | 1 | Direction at the port, 1 receive, 0 transmit |
| pktBcast | input | 1 | Packet is broadcast |
| pktMcast | input | 1 | Packet is multicast |
| decValid | output | 1 | Decision valid, one cycle after the strobe |
| decDrop | output | 1 | 1: drop the packet, 0: forward it |

## Verification
The hardest case to reach is a packet that lands in the very cycle the window closes, because the boundary depends on a prescaler that runs silently from reset. The bench keeps its own cycle count from reset and waits until the next cycle is the boundary. It then sends packets on counters that are already exhausted, so a design that clears counters one cycle early or late gives a different decision. Bursts of 255 multicast packets are also started right after a boundary, so that they fit inside one window and can reach the upper limit.

// File: rtl/bmc_rl_pkg.sv
package bmc_rl_pkg;
  localparam int PORT_IDX_W = 2;

  typedef struct packed {
    logic                  tick;     // window boundary this cycle
    logic                  valid;    // packet strobe present
    logic                  countEn;  // packet is subject to limiting
    logic                  isBcast;  // selects broadcast counter
    logic [PORT_IDX_W-1:0] port;
  } rlStrobe_t;
endpackage

// File: rtl/bmc_rl_ctrl.sv
module bmc_rl_ctrl
  import bmc_rl_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int HOST_PORT     = 0,
  parameter int WINDOW_CYCLES = 12_500_000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  limitRx,
  input  logic [NUM_PORTS-1:0]  portEnable,
  input  logic                  pktValid,
  input  logic [PORT_IDX_W-1:0] pktPort,
  input  logic                  pktRx,
  input  logic                  pktBcast,
  input  logic                  pktMcast,
  output rlStrobe_t             strobe
);
  localparam int PRE_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(WINDOW_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic             portOk, enSel, effRx, typed;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    portOk = 1'b0;
    enSel  = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (pktPort == PORT_IDX_W'(i)) begin
        portOk = 1'b1;
        enSel  = portEnable[i];
      end
    end
  end

  // host port sees transmit and receive swapped
  assign effRx = pktRx ^ (pktPort == PORT_IDX_W'(HOST_PORT));
  assign typed = pktBcast | pktMcast;

  always_comb begin
    strobe.tick    = tick;
    strobe.valid   = pktValid;
    strobe.countEn = pktValid && portOk && enSel && typed && (effRx == limitRx);
    strobe.isBcast = pktBcast;
    strobe.port    = pktPort;
  end

  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/bmc_rl_datapath.sv
module bmc_rl_datapath
  import bmc_rl_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int LIMIT_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rlStrobe_t                    strobe,
  input  logic [NUM_PORTS*LIMIT_W-1:0] bcastLimit,
  input  logic [NUM_PORTS*LIMIT_W-1:0] mcastLimit,
  output logic                         decValid,
  output logic                         decDrop
);
  localparam int NUM_CNT = NUM_PORTS * 2;  // index = port*2 + isBcast

  logic [LIMIT_W-1:0] cnt    [NUM_CNT];
  logic [LIMIT_W-1:0] limVal [NUM_CNT];
  logic [LIMIT_W-1:0] effSel, limSel;
  logic               allow, dropNow;
  logic [NUM_CNT-1:0] hitVec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign limVal[p*2]   = mcastLimit[p*LIMIT_W +: LIMIT_W];
    assign limVal[p*2+1] = bcastLimit[p*LIMIT_W +: LIMIT_W];
  end

  always_comb begin
    hitVec = '0;
    effSel = '0;
    limSel = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (strobe.countEn && (strobe.port == PORT_IDX_W'(i / 2))
          && (strobe.isBcast == ((i % 2) == 1))) begin
        hitVec[i] = 1'b1;
        effSel    = strobe.tick ? '0 : cnt[i];
        limSel    = limVal[i];
      end
    end
  end

  assign allow   = (effSel < limSel);
  assign dropNow = strobe.countEn && !allow;

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   cnt[c] <= '0;
      else if (hitVec[c] && allow) cnt[c] <= effSel + 1'b1;
      else if (strobe.tick)        cnt[c] <= '0;
    end

    a_r6_window_clear: assert property (@(posedge clk) disable iff (!rstN)
      strobe.tick |=> (cnt[c] <= LIMIT_W'(1)));
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.tick |=> (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) + 1'b1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      decDrop  <= 1'b0;
    end else begin
      decValid <= strobe.valid;
      decDrop  <= strobe.valid && dropNow;
    end
  end

  a_r5_zero_limit: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && limSel == '0) |=> decDrop);
  a_r4_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
endmodule

// File: rtl/bmc_rate_limiter.sv
module bmc_rate_limiter
  import bmc_rl_pkg::*;
#(
  parameter int NUM_PORTS     = 3,
  parameter int HOST_PORT     = 0,
  parameter int LIMIT_W       = 8,
  parameter int WINDOW_CYCLES = 12_500_000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         limitRx,
  input  logic [NUM_PORTS-1:0]         portEnable,
  input  logic [NUM_PORTS*LIMIT_W-1:0] bcastLimit,
  input  logic [NUM_PORTS*LIMIT_W-1:0] mcastLimit,
  input  logic                         pktValid,
  input  logic [PORT_IDX_W-1:0]        pktPort,
  input  logic                         pktRx,
  input  logic                         pktBcast,
  input  logic                         pktMcast,
  output logic                         decValid,
  output logic                         decDrop
);
  rlStrobe_t strobe;

  bmc_rl_ctrl #(
    .NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .limitRx(limitRx), .portEnable(portEnable),
    .pktValid(pktValid), .pktPort(pktPort), .pktRx(pktRx),
    .pktBcast(pktBcast), .pktMcast(pktMcast), .strobe(strobe)
  );

  bmc_rl_datapath #(
    .NUM_PORTS(NUM_PORTS), .LIMIT_W(LIMIT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bcastLimit(bcastLimit), .mcastLimit(mcastLimit),
    .decValid(decValid), .decDrop(decDrop)
  );

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> decValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |=> (!decValid && !decDrop));
  a_r10_unicast_pass: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktBcast && !pktMcast) |=> !decDrop);
  a_r12_bad_port_pass: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktPort >= PORT_IDX_W'(NUM_PORTS)) |=> !decDrop);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en_chk
    a_r9_disabled_pass: assert property (@(posedge clk) disable iff (!rstN)
      (pktValid && pktPort == PORT_IDX_W'(p) && !portEnable[p]) |=> !decDrop);
  end
endmodule

// File: tb/bmc_rate_limiter_test.sv
module bmc_rate_limiter_test;
  localparam int W = 400;
  localparam int NP = 3;

  logic clk = 0;
  logic rstN = 0;
  logic limitRx = 0;
  logic [2:0] portEnable = 3'b111;
  logic [23:0] bcastLimit, mcastLimit;
  logic pktValid = 0;
  logic [1:0] pktPort = 0;
  logic pktRx = 0, pktBcast = 0, pktMcast = 0;
  logic decValid, decDrop;

  always #5 clk = ~clk;

  bmc_rate_limiter #(.WINDOW_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .limitRx(limitRx), .portEnable(portEnable),
    .bcastLimit(bcastLimit), .mcastLimit(mcastLimit),
    .pktValid(pktValid), .pktPort(pktPort), .pktRx(pktRx),
    .pktBcast(pktBcast), .pktMcast(pktMcast),
    .decValid(decValid), .decDrop(decDrop)
  );

  int checks = 0, errors = 0;
  string phase = "R1";
  int drops = 0;

  // behavioural reference
  int mPre = 0;
  int mCnt [NP][2];
  bit expValid = 0, expDrop = 0;

  function automatic int limOf(int p, bit b);
    return b ? int'(bcastLimit[p*8 +: 8]) : int'(mcastLimit[p*8 +: 8]);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre = 0; expValid = 0; expDrop = 0;
      foreach (mCnt[i, j]) mCnt[i][j] = 0;
    end else begin
      bit isB, lim, dirRx;
      if (mPre == W-1) begin
        mPre = 0;
        foreach (mCnt[i, j]) mCnt[i][j] = 0;
      end else mPre++;
      expValid = pktValid;
      expDrop  = 0;
      isB = pktBcast;
      dirRx = (pktPort == 0) ? !pktRx : pktRx;
      lim = pktValid && pktPort < NP && portEnable[pktPort]
            && (pktBcast || pktMcast) && dirRx == limitRx;
      if (lim) begin
        if (mCnt[pktPort][isB] < limOf(pktPort, isB)) mCnt[pktPort][isB]++;
        else expDrop = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (decValid !== expValid || decDrop !== expDrop) begin
        errors++;
        $display("FAIL %s: valid/drop actual %b/%b expected %b/%b",
                 phase, decValid, decDrop, expValid, expDrop);
      end
      if (decValid && decDrop) drops++;
    end
  end

  task automatic send(input int p, input bit rx, input bit b, input bit m);
    pktValid = 1; pktPort = 2'(p); pktRx = rx; pktBcast = b; pktMcast = m;
    @(negedge clk);
    pktValid = 0; pktBcast = 0; pktMcast = 0;
  endtask

  task automatic toBoundary();  // next edge will be the window boundary
    while (mPre != W-1) @(negedge clk);
  endtask

  task automatic expectDrops(input string tag, input int want);
    @(negedge clk);
    checks++;
    if (drops != want) begin
      errors++;
      $display("FAIL %s: drop count actual %0d expected %0d", tag, drops, want);
    end
    drops = 0;
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // port0 b2 m4, port1 b3 m1, port2 b0 m255
    bcastLimit = {8'd0, 8'd3, 8'd2};
    mcastLimit = {8'd255, 8'd1, 8'd4};
    repeat (3) @(negedge clk);
    checks++;
    if (decValid !== 0 || decDrop !== 0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %b%b expected 00", decValid, decDrop);
    end
    rstN = 1;
    @(negedge clk);

    phase = "R3"; drops = 0;
    toBoundary();
    for (int i = 0; i < 5; i++) send(1, 0, 1, 0);
    expectDrops("R3", 2);

    phase = "R4";
    for (int i = 0; i < 3; i++) send(1, 0, 0, 1);   // mcast p1 limit1 -> 2 drops
    for (int i = 0; i < 3; i++) send(0, 1, 1, 0);   // p0 rx = tx view, limit2 -> 1
    expectDrops("R4", 3);

    phase = "R10";
    for (int i = 0; i < 4; i++) send(1, 0, 0, 0);
    expectDrops("R10", 0);

    phase = "R11";
    send(1, 0, 1, 1);  // p1 bcast already exhausted
    expectDrops("R11", 1);

    phase = "R6";
    toBoundary();
    send(1, 0, 1, 0); send(1, 0, 1, 0); send(1, 0, 1, 0); send(1, 0, 1, 0);
    expectDrops("R6", 1);

    phase = "R5";
    toBoundary();
    for (int i = 0; i < 258; i++) send(2, 0, 0, 1);
    expectDrops("R5", 3);
    for (int i = 0; i < 3; i++) send(2, 0, 1, 0);
    expectDrops("R5", 3);

    phase = "R7";
    toBoundary();
    for (int i = 0; i < 4; i++) send(1, 1, 1, 0);  // receive, not limited
    expectDrops("R7", 0);
    limitRx = 1;
    for (int i = 0; i < 4; i++) send(1, 1, 1, 0);
    expectDrops("R7", 1);

    phase = "R8";
    for (int i = 0; i < 3; i++) send(0, 1, 1, 0);  // host: rx means tx, not limited now
    expectDrops("R8", 0);
    for (int i = 0; i < 3; i++) send(0, 0, 1, 0);
    expectDrops("R8", 1);

    phase = "R9";
    portEnable = 3'b011;
    for (int i = 0; i < 3; i++) send(2, 1, 1, 0);
    expectDrops("R9", 0);
    portEnable = 3'b111;

    phase = "R12";
    for (int i = 0; i < 3; i++) send(3, 1, 1, 1);
    expectDrops("R12", 0);

    phase = "R2";
    send(1, 1, 0, 0); repeat (3) @(negedge clk);
    send(2, 1, 0, 1); send(2, 1, 0, 1);
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule